// File: doc/BRIEF.md
# Configuration Access Bridge with Base-Address Interception

The bridge sits on the host side of a configuration fabric. The host first stores a 32-bit target word in an address latch. The word holds an enable flag, a bus number, a device/function number and a dword register index. The host then reads or writes 1, 2 or 4 bytes through a data window. The bridge decodes the target against a table of device configuration spaces fixed at elaboration. It routes the access to the selected space. Accesses that are disabled, misaligned or aimed at an empty slot read as zero and change nothing.

Writes to the base-address dwords get special handling. A full-width write to one of the region dwords that belongs to a region with a nonzero size is not stored as written. The bridge first masks off the bits below the region size, then adds the region's type bit. An all-ones probe therefore reads back as the size mask. Any other nonzero value also moves the region: the bridge emits a one-cycle remap pulse that carries the device slot, the region index, the previous base and the new base.

Some table entries ask for automatic placement. Each of these takes the lowest free device/function number that is a multiple of 8 on its bus.

Top module: `cfg_access_bridge`

## Requirements
- R1: A host access with `host_sel`=0 writes the full 32-bit address latch. A read with `host_sel`=0 returns the latch in `host_rdata` in the cycle after the request.
- R2: A data-window access (`host_sel`=1) made while latch bit 31 is 0 stores nothing and reads as 0.
- R3: A data-window access made while latch bits 1:0 are nonzero stores nothing and reads as 0.
- R4: The latch selects the bus with bits 23:16 and the device/function with bits 15:8. If no table entry matches both fields, the access reads 0 and the write is dropped.
- R5: The config byte offset is {latch[7:2], `host_port_lo`}. `host_size` codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes, stored little-endian from the offset. A 1- or 2-byte read returns the addressed bytes right-justified with the upper bits 0. Bytes at or beyond CFG_BYTES read 0 and ignore writes.
- R6: Only a 4-byte write whose offset lies in 0x10..(0x0F+4*NUM_BARS) targets region (offset−0x10)/4. For such a write the stored dword at 0x10+4*region is (value AND NOT(size−1)) OR type, where type is 1 for I/O regions and 0 for memory regions. An all-ones write therefore reads back as the size mask. Narrower writes to these offsets are ordinary writes.
- R7: A 4-byte write to the dword of a region whose size is 0 is stored as an ordinary write and gives no remap pulse.
- R8: A region write whose value is neither 0 nor 0xFFFFFFFF sets `remap_valid` for exactly the next cycle. The pulse carries the device slot, the region, the previous base and the new base: the value with bits 1:0 cleared for I/O regions, or bits 3:0 cleared for memory regions. Every base resets to 0xFFFFFFFF.
- R9: Region writes of 0 or 0xFFFFFFFF give no remap pulse and leave the region base unchanged.
- R10: A table entry flagged for automatic placement takes the lowest device/function number that is a multiple of 8 and not used by a fixed entry or an earlier placed entry on the same bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request, one cycle per access |
| host_write | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = address latch, 1 = data window |
| host_port_lo | input | 2 | Low two bits of the data-window port address |
| host_size | input | 2 | Access width code (0:1B, 1:2B, 2/3:4B) |
| host_wdata | input | 32 | Write data, right-justified |
| host_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| remap_valid | output | 1 | One-cycle region relocation pulse |
| remap_dev | output | DEV_W | Device slot of the relocated region |
| remap_region | output | BAR_W | Region index |
| remap_old_base | output | 32 | Base before relocation |
| remap_new_base | output | 32 | Base after relocation |

## Verification
The bench writes distinct values to a memory region and to two I/O regions of different sizes. All-ones probes show whether each size mask and type bit is correct. Zero writes separate the "store, no relocation" path from the relocation path. Non-aligned values show that bits are cleared by region type. A chain of relocations confirms that the reported old base follows the last real relocation and is not affected by probes. Narrow writes and writes to zero-size regions at the same offsets show that interception depends on width and region size, not on offset alone. Disabled, misaligned and unpopulated targets are each tried against a space that was written earlier, so a dropped write can be told apart from a cleared one.

// File: rtl/cab_pkg.sv
package cab_pkg;

   localparam int ADDR_W   = 32;
   localparam int BAR_LO   = 16;

   typedef struct packed {
      logic       enable;
      logic [6:0] rsvd;
      logic [7:0] bus;
      logic [7:0] devfn;
      logic [5:0] dword;
      logic [1:0] low;
   } cfg_addr_t;

   typedef enum logic [1:0] {
      ACC_BYTE  = 2'd0,
      ACC_HALF  = 2'd1,
      ACC_WORD  = 2'd2,
      ACC_WORD3 = 2'd3
   } acc_size_e;

   function automatic logic [2:0] acc_len(input logic [1:0] sz);
      case (acc_size_e'(sz))
         ACC_BYTE: return 3'd1;
         ACC_HALF: return 3'd2;
         default:  return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/cab_decode.sv
module cab_decode
   import cab_pkg::*;
#(
   parameter int                          NUM_DEV   = 3,
   parameter int                          DEV_W     = 2,
   parameter logic [NUM_DEV-1:0][7:0]     DEV_BUS   = '0,
   parameter logic [NUM_DEV-1:0][7:0]     DEV_DEVFN = '0,
   parameter logic [NUM_DEV-1:0]          DEV_AUTO  = '0
) (
   input  logic             enable,
   input  logic [1:0]       low,
   input  logic [7:0]       bus,
   input  logic [7:0]       devfn,
   output logic             hit,
   output logic [DEV_W-1:0] dev_sel
);

   // Resolve automatic placement at elaboration: {present mask, devfn table}
   function automatic logic [NUM_DEV*9-1:0] place_table();
      logic [NUM_DEV-1:0][7:0] fn;
      logic [NUM_DEV-1:0]      ok;
      logic                    free;
      fn = DEV_DEVFN;
      ok = ~DEV_AUTO;
      for (int i = 0; i < NUM_DEV; i++) begin
         if (DEV_AUTO[i]) begin
            for (int c = 0; c < 32; c++) begin
               if (!ok[i]) begin
                  free = 1'b1;
                  for (int j = 0; j < NUM_DEV; j++)
                     if (ok[j] && DEV_BUS[j] == DEV_BUS[i] && fn[j] == 8'(c * 8))
                        free = 1'b0;
                  if (free) begin
                     fn[i] = 8'(c * 8);
                     ok[i] = 1'b1;
                  end
               end
            end
         end
      end
      return {ok, fn};
   endfunction

   localparam logic [NUM_DEV*9-1:0]      PLACED   = place_table();
   localparam logic [NUM_DEV-1:0][7:0]   SLOT_FN  = PLACED[NUM_DEV*8-1:0];
   localparam logic [NUM_DEV-1:0]        SLOT_OK  = PLACED[NUM_DEV*9-1:NUM_DEV*8];

   logic [NUM_DEV-1:0] match;

   generate
      for (genvar i = 0; i < NUM_DEV; i++) begin : g_match
         assign match[i] = SLOT_OK[i] && (bus == DEV_BUS[i]) && (devfn == SLOT_FN[i]);
      end
   endgenerate

   always_comb begin
      hit     = 1'b0;
      dev_sel = '0;
      if (enable && low == 2'b00) begin
         for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (match[i]) begin
               hit     = 1'b1;
               dev_sel = DEV_W'(i);
            end
         end
      end
   end

endmodule

// File: rtl/cab_dev_space.sv
module cab_dev_space
   import cab_pkg::*;
#(
   parameter int                           NUM_BARS  = 6,
   parameter int                           BAR_W     = 3,
   parameter int                           CFG_BYTES = 64,
   parameter logic [NUM_BARS-1:0][31:0]    BAR_SIZE  = '0,
   parameter logic [NUM_BARS-1:0]          BAR_IO    = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       offset,
   input  logic [2:0]       len,
   input  logic [31:0]      wdata,
   output logic [31:0]      rd_word,
   output logic             remap_req,
   output logic [BAR_W-1:0] remap_region,
   output logic [31:0]      remap_old,
   output logic [31:0]      remap_new
);

   localparam int BAR_HI = BAR_LO + 4 * NUM_BARS;

   // Elaboration-time parameter checks
   generate
      if (CFG_BYTES < BAR_HI || CFG_BYTES > 256) begin : g_bad_bytes
         $error("cab_dev_space: CFG_BYTES must cover the region dwords and fit 8 bits");
      end
      for (genvar r = 0; r < NUM_BARS; r++) begin : g_chk
         if ((BAR_SIZE[r] & (BAR_SIZE[r] - 32'd1)) != 32'd0) begin : g_pow2
            $error("cab_dev_space: region size must be a power of two");
         end
         if (BAR_SIZE[r] != 32'd0 && BAR_SIZE[r] < 32'd4) begin : g_min
            $error("cab_dev_space: nonzero region size must be at least 4");
         end
      end
   endgenerate

   logic [CFG_BYTES-1:0][7:0] mem_q;
   logic [NUM_BARS-1:0][31:0] base_q;
   logic [CFG_BYTES-1:0]      byte_we;
   logic [CFG_BYTES-1:0][7:0] byte_wd;

   int          off_i;
   int          bar_i;
   int          bar_byte;
   logic        in_win;
   logic        bar_take;
   logic        relocate;
   logic [31:0] sel_size;
   logic        sel_io;
   logic [31:0] sel_base;
   logic [31:0] stored;
   logic [31:0] new_base;

   // Region interception decode
   always_comb begin
      off_i    = int'(offset);
      in_win   = (len == 3'd4) && (off_i >= BAR_LO) && (off_i < BAR_HI);
      bar_i    = in_win ? ((off_i - BAR_LO) >> 2) : 0;
      bar_byte = BAR_LO + 4 * bar_i;
      sel_size = '0;
      sel_io   = 1'b0;
      sel_base = '1;
      for (int r = 0; r < NUM_BARS; r++) begin
         if (in_win && r == bar_i) begin
            sel_size = BAR_SIZE[r];
            sel_io   = BAR_IO[r];
            sel_base = base_q[r];
         end
      end
      bar_take = in_win && (sel_size != 32'd0);
      relocate = bar_take && (wdata != 32'hFFFF_FFFF) && (wdata != 32'd0);
      stored   = (wdata & ~(sel_size - 32'd1)) | {31'd0, sel_io};
      new_base = sel_io ? {wdata[31:2], 2'b00} : {wdata[31:4], 4'b0000};
   end

   // Per-byte write enables and data
   always_comb begin
      for (int b = 0; b < CFG_BYTES; b++) begin
         byte_we[b] = 1'b0;
         byte_wd[b] = 8'd0;
         if (bar_take) begin
            if (b >= bar_byte && b < bar_byte + 4) begin
               byte_we[b] = wr_en;
               byte_wd[b] = stored[8*(b-bar_byte) +: 8];
            end
         end else if (b >= off_i && b < off_i + int'(len)) begin
            byte_we[b] = wr_en;
            byte_wd[b] = wdata[8*(b-off_i) +: 8];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
      end else begin
         for (int b = 0; b < CFG_BYTES; b++)
            if (byte_we[b]) mem_q[b] <= byte_wd[b];
      end
   end

   generate
      for (genvar r = 0; r < NUM_BARS; r++) begin : g_base
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               base_q[r] <= '1;
            else if (wr_en && relocate && bar_i == r)
               base_q[r] <= new_base;
         end
      end
   endgenerate

   // Right-justified read of len bytes from offset
   always_comb begin
      rd_word = '0;
      for (int k = 0; k < 4; k++) begin
         for (int b = 0; b < CFG_BYTES; b++) begin
            if (k < int'(len) && b == off_i + k)
               rd_word[8*k +: 8] = mem_q[b];
         end
      end
   end

   assign remap_req    = wr_en && relocate;
   assign remap_region = BAR_W'(bar_i);
   assign remap_old    = sel_base;
   assign remap_new    = new_base;

endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
   import cab_pkg::*;
#(
   parameter int NUM_DEV   = 3,
   parameter int NUM_BARS  = 6,
   parameter int CFG_BYTES = 64,
   parameter int DEV_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
   parameter int BAR_W     = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1,
   parameter logic [NUM_DEV-1:0][7:0] DEV_BUS   = {8'h01, 8'h00, 8'h00},
   parameter logic [NUM_DEV-1:0][7:0] DEV_DEVFN = {8'h13, 8'h00, 8'h00},
   parameter logic [NUM_DEV-1:0]      DEV_AUTO  = 3'b010,
   parameter logic [NUM_DEV-1:0][NUM_BARS-1:0][31:0] BAR_SIZE = {
      {32'h0, 32'h0, 32'h0, 32'h0,    32'h0, 32'h0},
      {32'h0, 32'h0, 32'h0, 32'h1000, 32'h4, 32'h8},
      {32'h0, 32'h0, 32'h0, 32'h0,    32'h0, 32'h100}},
   parameter logic [NUM_DEV-1:0][NUM_BARS-1:0] BAR_IO = {6'b000000, 6'b000011, 6'b000000}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_valid,
   input  logic             host_write,
   input  logic             host_sel,
   input  logic [1:0]       host_port_lo,
   input  logic [1:0]       host_size,
   input  logic [31:0]      host_wdata,
   output logic [31:0]      host_rdata,
   output logic             remap_valid,
   output logic [DEV_W-1:0] remap_dev,
   output logic [BAR_W-1:0] remap_region,
   output logic [31:0]      remap_old_base,
   output logic [31:0]      remap_new_base
);

   generate
      if (NUM_DEV < 1 || NUM_BARS < 1 || NUM_BARS > 6) begin : g_bad_cfg
         $error("cfg_access_bridge: NUM_DEV >= 1 and 1 <= NUM_BARS <= 6 required");
      end
   endgenerate

   cfg_addr_t          addr_q;
   logic               hit;
   logic [DEV_W-1:0]   dev_sel;
   logic [7:0]         cfg_off;
   logic [2:0]         len;
   logic               win_wr;

   logic [NUM_DEV-1:0][31:0]      dev_rd;
   logic [NUM_DEV-1:0]            dev_req;
   logic [NUM_DEV-1:0][BAR_W-1:0] dev_reg;
   logic [NUM_DEV-1:0][31:0]      dev_old;
   logic [NUM_DEV-1:0][31:0]      dev_new;

   assign cfg_off = {addr_q.dword, host_port_lo};
   assign len     = acc_len(host_size);
   assign win_wr  = host_valid && host_write && host_sel && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (host_valid && host_write && !host_sel)
         addr_q <= cfg_addr_t'(host_wdata);
   end

   cab_decode #(
      .NUM_DEV   (NUM_DEV),
      .DEV_W     (DEV_W),
      .DEV_BUS   (DEV_BUS),
      .DEV_DEVFN (DEV_DEVFN),
      .DEV_AUTO  (DEV_AUTO)
   ) decode_i (
      .enable  (addr_q.enable),
      .low     (addr_q.low),
      .bus     (addr_q.bus),
      .devfn   (addr_q.devfn),
      .hit     (hit),
      .dev_sel (dev_sel)
   );

   generate
      for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
         cab_dev_space #(
            .NUM_BARS  (NUM_BARS),
            .BAR_W     (BAR_W),
            .CFG_BYTES (CFG_BYTES),
            .BAR_SIZE  (BAR_SIZE[i]),
            .BAR_IO    (BAR_IO[i])
         ) space_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (win_wr && dev_sel == DEV_W'(i)),
            .offset       (cfg_off),
            .len          (len),
            .wdata        (host_wdata),
            .rd_word      (dev_rd[i]),
            .remap_req    (dev_req[i]),
            .remap_region (dev_reg[i]),
            .remap_old    (dev_old[i]),
            .remap_new    (dev_new[i])
         );
      end
   endgenerate

   logic [31:0]      win_rd;
   logic             any_req;
   logic [DEV_W-1:0] req_dev;
   logic [BAR_W-1:0] req_reg;
   logic [31:0]      req_old;
   logic [31:0]      req_new;

   always_comb begin
      win_rd  = '0;
      any_req = 1'b0;
      req_dev = '0;
      req_reg = '0;
      req_old = '0;
      req_new = '0;
      for (int i = 0; i < NUM_DEV; i++) begin
         if (hit && dev_sel == DEV_W'(i))
            win_rd = dev_rd[i];
         if (dev_req[i]) begin
            any_req = 1'b1;
            req_dev = DEV_W'(i);
            req_reg = dev_reg[i];
            req_old = dev_old[i];
            req_new = dev_new[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else if (host_valid && !host_write) begin
         host_rdata <= host_sel ? win_rd : addr_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remap_valid    <= 1'b0;
         remap_dev      <= '0;
         remap_region   <= '0;
         remap_old_base <= '0;
         remap_new_base <= '0;
      end else begin
         remap_valid <= any_req;
         if (any_req) begin
            remap_dev      <= req_dev;
            remap_region   <= req_reg;
            remap_old_base <= req_old;
            remap_new_base <= req_new;
         end
      end
   end

endmodule

// File: rtl/cab_checker.sv
module cab_checker #(
   parameter int NUM_BARS = 6,
   parameter int BAR_W    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_valid,
   input logic             host_write,
   input logic             host_sel,
   input logic [1:0]       host_size,
   input logic [31:0]      host_rdata,
   input logic [31:0]      addr_q,
   input logic             remap_valid,
   input logic [BAR_W-1:0] remap_region,
   input logic [31:0]      remap_new_base
);

   assert_addr_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && !host_write && !host_sel) |=> (host_rdata == $past(addr_q)));

   assert_disabled_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && !host_write && host_sel && !addr_q[31]) |=> (host_rdata == 32'd0));

   assert_misaligned_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && !host_write && host_sel && addr_q[1:0] != 2'b00) |=> (host_rdata == 32'd0));

   assert_byte_read_justified_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && !host_write && host_sel && host_size == 2'd0) |=> (host_rdata[31:8] == 24'd0));

   assert_half_read_justified_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_valid && !host_write && host_sel && host_size == 2'd1) |=> (host_rdata[31:16] == 16'd0));

   assert_remap_after_word_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      remap_valid |-> $past(host_valid && host_write && host_sel && host_size[1]));

   assert_remap_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
      remap_valid |-> (int'(remap_region) < NUM_BARS && remap_new_base[1:0] == 2'b00));

endmodule

bind cfg_access_bridge cab_checker #(
   .NUM_BARS (NUM_BARS),
   .BAR_W    (BAR_W)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .host_valid     (host_valid),
   .host_write     (host_write),
   .host_sel       (host_sel),
   .host_size      (host_size),
   .host_rdata     (host_rdata),
   .addr_q         (addr_q),
   .remap_valid    (remap_valid),
   .remap_region   (remap_region),
   .remap_new_base (remap_new_base)
);

// File: tb/cfg_access_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_access_bridge_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_valid = 1'b0;
   logic        host_write = 1'b0;
   logic        host_sel = 1'b0;
   logic [1:0]  host_port_lo = 2'd0;
   logic [1:0]  host_size = 2'd2;
   logic [31:0] host_wdata = 32'd0;
   logic [31:0] host_rdata;
   logic        remap_valid;
   logic [1:0]  remap_dev;
   logic [2:0]  remap_region;
   logic [31:0] remap_old_base;
   logic [31:0] remap_new_base;

   always #5 clk = ~clk;

   cfg_access_bridge dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .host_valid     (host_valid),
      .host_write     (host_write),
      .host_sel       (host_sel),
      .host_port_lo   (host_port_lo),
      .host_size      (host_size),
      .host_wdata     (host_wdata),
      .host_rdata     (host_rdata),
      .remap_valid    (remap_valid),
      .remap_dev      (remap_dev),
      .remap_region   (remap_region),
      .remap_old_base (remap_old_base),
      .remap_new_base (remap_new_base)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [31:0] rd;
   logic        rv;
   logic [1:0]  rdev;
   logic [2:0]  rreg;
   logic [31:0] rold, rnew;

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", tag, got, exp);
      end
   endtask

   task automatic do_op(input logic sel, input logic wr, input logic [1:0] sz,
                        input logic [1:0] port, input logic [31:0] data);
      @(negedge clk);
      host_valid   = 1'b1;
      host_write   = wr;
      host_sel     = sel;
      host_size    = sz;
      host_port_lo = port;
      host_wdata   = data;
      @(posedge clk);
      #1;
      host_valid = 1'b0;
      rd   = host_rdata;
      rv   = remap_valid;
      rdev = remap_dev;
      rreg = remap_region;
      rold = remap_old_base;
      rnew = remap_new_base;
   endtask

   function automatic logic [31:0] mk(input logic [7:0] bus, input logic [7:0] fn,
                                     input logic [5:0] dw);
      return {1'b1, 7'd0, bus, fn, dw, 2'b00};
   endfunction

   task automatic cfg_wr(input logic [31:0] a, input logic [1:0] sz,
                         input logic [1:0] port, input logic [31:0] d);
      do_op(1'b0, 1'b1, 2'd2, 2'd0, a);
      do_op(1'b1, 1'b1, sz, port, d);
   endtask

   task automatic cfg_rd(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] port);
      do_op(1'b0, 1'b1, 2'd2, 2'd0, a);
      do_op(1'b1, 1'b0, sz, port, 32'd0);
   endtask

   task automatic t_reset();
      check("R1 reset rdata", host_rdata, 32'd0);
      check("R8 reset remap_valid", {31'd0, remap_valid}, 32'd0);
      do_op(1'b0, 1'b0, 2'd2, 2'd0, 32'd0);
      check("R1 reset latch", rd, 32'd0);
   endtask

   task automatic t_addr_latch();
      do_op(1'b0, 1'b1, 2'd2, 2'd0, 32'h1234_5678);
      do_op(1'b0, 1'b0, 2'd2, 2'd0, 32'd0);
      check("R1 latch readback", rd, 32'h1234_5678);
   endtask

   task automatic t_ordinary();
      cfg_wr(mk(8'h00, 8'h00, 6'h0C), 2'd2, 2'd0, 32'hA1B2_C3D4);
      cfg_rd(mk(8'h00, 8'h00, 6'h0C), 2'd2, 2'd0);
      check("R5 word read", rd, 32'hA1B2_C3D4);
      cfg_rd(mk(8'h00, 8'h00, 6'h0C), 2'd0, 2'd2);
      check("R5 byte read port2", rd, 32'h0000_00B2);
      cfg_rd(mk(8'h00, 8'h00, 6'h0C), 2'd1, 2'd1);
      check("R5 half read port1", rd, 32'h0000_B2C3);
      cfg_wr(mk(8'h00, 8'h00, 6'h0C), 2'd0, 2'd3, 32'h0000_005E);
      cfg_rd(mk(8'h00, 8'h00, 6'h0C), 2'd2, 2'd0);
      check("R5 byte write port3", rd, 32'h5EB2_C3D4);
      cfg_wr(mk(8'h00, 8'h00, 6'h20), 2'd2, 2'd0, 32'hDEAD_BEEF);
      cfg_rd(mk(8'h00, 8'h00, 6'h20), 2'd2, 2'd0);
      check("R5 beyond space reads zero", rd, 32'd0);
   endtask

   task automatic t_disabled();
      cfg_wr(mk(8'h00, 8'h00, 6'h0C) & 32'h7FFF_FFFF, 2'd2, 2'd0, 32'hFFFF_FFFF);
      do_op(1'b1, 1'b0, 2'd2, 2'd0, 32'd0);
      check("R2 disabled read zero", rd, 32'd0);
      cfg_rd(mk(8'h00, 8'h00, 6'h0C), 2'd2, 2'd0);
      check("R2 disabled write dropped", rd, 32'h5EB2_C3D4);
   endtask

   task automatic t_misaligned();
      cfg_wr(mk(8'h00, 8'h00, 6'h0C) | 32'd1, 2'd2, 2'd0, 32'd0);
      do_op(1'b1, 1'b0, 2'd2, 2'd0, 32'd0);
      check("R3 misaligned read zero", rd, 32'd0);
      cfg_rd(mk(8'h00, 8'h00, 6'h0C), 2'd2, 2'd0);
      check("R3 misaligned write dropped", rd, 32'h5EB2_C3D4);
   endtask

   task automatic t_decode();
      cfg_rd(mk(8'h00, 8'h10, 6'h0C), 2'd2, 2'd0);
      check("R4 empty devfn reads zero", rd, 32'd0);
      cfg_wr(mk(8'h01, 8'h13, 6'h03), 2'd2, 2'd0, 32'h600D_F00D);
      cfg_rd(mk(8'h01, 8'h13, 6'h03), 2'd2, 2'd0);
      check("R4 bus1 device readback", rd, 32'h600D_F00D);
      cfg_wr(mk(8'h01, 8'h12, 6'h03), 2'd2, 2'd0, 32'd0);
      cfg_rd(mk(8'h01, 8'h13, 6'h03), 2'd2, 2'd0);
      check("R4 neighbour devfn write dropped", rd, 32'h600D_F00D);
      cfg_rd(mk(8'h02, 8'h13, 6'h03), 2'd2, 2'd0);
      check("R4 empty bus reads zero", rd, 32'd0);
   endtask

   task automatic t_autoplace();
      cfg_wr(mk(8'h00, 8'h08, 6'h0C), 2'd2, 2'd0, 32'h1122_3344);
      cfg_rd(mk(8'h00, 8'h08, 6'h0C), 2'd2, 2'd0);
      check("R10 auto slot at devfn 08", rd, 32'h1122_3344);
      cfg_rd(mk(8'h00, 8'h00, 6'h0C), 2'd2, 2'd0);
      check("R10 fixed slot at devfn 00 untouched", rd, 32'h5EB2_C3D4);
   endtask

   task automatic t_probe();
      cfg_wr(mk(8'h00, 8'h08, 6'h04), 2'd2, 2'd0, 32'hFFFF_FFFF);
      check("R9 all-ones no remap", {31'd0, rv}, 32'd0);
      cfg_rd(mk(8'h00, 8'h08, 6'h04), 2'd2, 2'd0);
      check("R6 io size8 mask", rd, 32'hFFFF_FFF9);
      cfg_wr(mk(8'h00, 8'h08, 6'h05), 2'd2, 2'd0, 32'hFFFF_FFFF);
      cfg_rd(mk(8'h00, 8'h08, 6'h05), 2'd2, 2'd0);
      check("R6 io size4 mask", rd, 32'hFFFF_FFFD);
      cfg_wr(mk(8'h00, 8'h08, 6'h06), 2'd2, 2'd0, 32'hFFFF_FFFF);
      cfg_rd(mk(8'h00, 8'h08, 6'h06), 2'd2, 2'd0);
      check("R6 mem size 1000 mask", rd, 32'hFFFF_F000);
      cfg_wr(mk(8'h00, 8'h00, 6'h04), 2'd2, 2'd0, 32'hFFFF_FFFF);
      cfg_rd(mk(8'h00, 8'h00, 6'h04), 2'd2, 2'd0);
      check("R6 mem size 100 mask", rd, 32'hFFFF_FF00);
      cfg_wr(mk(8'h00, 8'h08, 6'h04), 2'd2, 2'd0, 32'd0);
      check("R9 zero no remap", {31'd0, rv}, 32'd0);
      cfg_rd(mk(8'h00, 8'h08, 6'h04), 2'd2, 2'd0);
      check("R6 zero write keeps type", rd, 32'h0000_0001);
   endtask

   task automatic t_relocate();
      cfg_wr(mk(8'h00, 8'h08, 6'h04), 2'd2, 2'd0, 32'h0000_C103);
      check("R8 remap pulse", {31'd0, rv}, 32'd1);
      check("R8 remap dev", {30'd0, rdev}, 32'd1);
      check("R8 remap region", {29'd0, rreg}, 32'd0);
      check("R8 remap old reset base", rold, 32'hFFFF_FFFF);
      check("R8 remap new io base", rnew, 32'h0000_C100);
      cfg_rd(mk(8'h00, 8'h08, 6'h04), 2'd2, 2'd0);
      check("R8 single cycle pulse", {31'd0, rv}, 32'd0);
      check("R6 io stored value", rd, 32'h0000_C101);
      cfg_wr(mk(8'h00, 8'h08, 6'h04), 2'd2, 2'd0, 32'h0000_C201);
      check("R8 second old base", rold, 32'h0000_C100);
      check("R8 second new base", rnew, 32'h0000_C200);
      cfg_wr(mk(8'h00, 8'h08, 6'h06), 2'd2, 2'd0, 32'hE000_1237);
      check("R8 mem region index", {29'd0, rreg}, 32'd2);
      check("R8 mem new base", rnew, 32'hE000_1230);
      cfg_rd(mk(8'h00, 8'h08, 6'h06), 2'd2, 2'd0);
      check("R6 mem stored value", rd, 32'hE000_1000);
      cfg_wr(mk(8'h00, 8'h08, 6'h04), 2'd2, 2'd0, 32'hFFFF_FFFF);
      cfg_wr(mk(8'h00, 8'h08, 6'h04), 2'd2, 2'd0, 32'h0000_C301);
      check("R9 probe left base unchanged", rold, 32'h0000_C200);
   endtask

   task automatic t_fallback();
      cfg_wr(mk(8'h00, 8'h08, 6'h07), 2'd2, 2'd0, 32'h1234_5678);
      check("R7 zero-size no remap", {31'd0, rv}, 32'd0);
      cfg_rd(mk(8'h00, 8'h08, 6'h07), 2'd2, 2'd0);
      check("R7 zero-size ordinary store", rd, 32'h1234_5678);
      cfg_wr(mk(8'h00, 8'h08, 6'h04), 2'd1, 2'd0, 32'h0000_ABCD);
      check("R6 narrow write no remap", {31'd0, rv}, 32'd0);
      cfg_rd(mk(8'h00, 8'h08, 6'h04), 2'd2, 2'd0);
      check("R6 narrow write ordinary", rd, 32'h0000_ABCD);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_addr_latch();
      t_ordinary();
      t_disabled();
      t_misaligned();
      t_decode();
      t_autoplace();
      t_probe();
      t_relocate();
      t_fallback();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule